// File: doc/BRIEF.md
# Implementation-Defined System Register Bank

This block holds the small set of implementation-defined system-coprocessor registers of a compact CPU core. The core presents one access per cycle as a single-cycle valid strobe with the selector fields `crn`, `crm`, `opc1` and `opc2`, a write flag, write data and the current privilege level. The bank answers with registered read data and an undefined-access flag one cycle later.

Besides plain storage, two locations have side effects. A configuration bit picks which of two identification words the core reports. A write to the status location raises a one-cycle halt request. A catch-all input turns the whole `crn=15` space into read-as-zero, write-ignored locations for cores that need no specific behaviour here.

Top module: `impdef_reg_bank`

## Requirements
- R1: After reset every register reads zero, `cpu_id_o` equals the primary ID, and `rdata_o`, `undef_o` and `halt_o` are zero.
- R2: A write to the configuration register (crm=1) keeps only the bits under mask 0xE7; all other bits read back as zero.
- R3: `cpu_id_o` is the alternate ID when bit 5 of the configuration register is 1 and the primary ID when it is 0, and it changes on the clock edge that takes the write.
- R4: The upper-limit (crm=2) and lower-limit (crm=3) registers store and return all 32 bits of the written value.
- R5: The thread-ID register (crm=4) keeps only bits 15:0 of the written value.
- R6: A write to the status location (crm=8) makes `halt_o` high for exactly the one cycle after the request. A read of it returns zero. `halt_o` and `undef_o` are never high together.
- R7: The reserved location crm=0 reads zero, drops writes, and is not flagged undefined.
- R8: With catch-all off, a crn=15 access with opc1 or opc2 nonzero, or with a crm other than 0, 1, 2, 3, 4 or 8, raises `undef_o` for one cycle, returns zero on a read, and changes no register.
- R9: With catch-all off, a crn=15 access at a privilege level below 1 raises `undef_o` for one cycle, returns zero on a read, and changes no register.
- R10: With `catch_all_i` high, every crn=15 access reads zero and changes no register, and neither `undef_o` nor `halt_o` is raised.
- R11: Read data appears on `rdata_o` in the cycle after the read request and holds until the next crn=15 read. Requests with crn other than 15 change no output and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Single-cycle access strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_crn_i | input | 4 | Primary register selector |
| req_crm_i | input | 4 | Secondary register selector |
| req_opc1_i | input | 3 | First opcode field |
| req_opc2_i | input | 3 | Second opcode field |
| req_priv_i | input | 2 | Privilege level of the access |
| req_wdata_i | input | 32 | Write data |
| catch_all_i | input | 1 | Read-as-zero, write-ignored mode for all of crn=15 |
| rdata_o | output | 32 | Registered read data |
| undef_o | output | 1 | One-cycle undefined-access flag |
| halt_o | output | 1 | One-cycle halt request |
| cpu_id_o | output | 32 | Reported identification word |

## Verification
A write can change the register state and raise an output flag in the same cycle. A status write at low privilege, or with nonzero opcode fields, must raise the undefined flag and must not raise the halt request. The same write with catch-all high must raise neither. The sweep crosses every crm with both opcode variants, every privilege level, both directions and both catch-all settings. Each access is judged against a bench model: halt, undefined flag, read data and identification word must all match in the cycle after the request. Afterwards every register is read back to show that no rejected write changed it.

// File: rtl/impdef_pkg.sv
package impdef_pkg;
  typedef enum logic [2:0] {
    SEL_NONE, SEL_RSVD, SEL_CFG, SEL_UPPER, SEL_LOWER, SEL_TID, SEL_STAT
  } reg_sel_e;

  typedef struct packed {
    logic     hit;    // crn=15 access
    logic     undef;  // flagged undefined
    logic     quiet;  // catch-all: RAZ/WI
    reg_sel_e sel;
  } dec_t;
endpackage

// File: rtl/impdef_decode.sv
module impdef_decode
  import impdef_pkg::*;
#(
  parameter int PRIV_W   = 2,
  parameter int MIN_PRIV = 1
) (
  input  logic [3:0]        crn_i,
  input  logic [3:0]        crm_i,
  input  logic [2:0]        opc1_i,
  input  logic [2:0]        opc2_i,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic              catch_all_i,
  output dec_t              dec_o
);
  localparam logic [PRIV_W-1:0] MinPriv = PRIV_W'(MIN_PRIV);

  reg_sel_e sel;
  logic     priv_ok, opc_ok;

  always_comb begin
    unique case (crm_i)
      4'd0:    sel = SEL_RSVD;
      4'd1:    sel = SEL_CFG;
      4'd2:    sel = SEL_UPPER;
      4'd3:    sel = SEL_LOWER;
      4'd4:    sel = SEL_TID;
      4'd8:    sel = SEL_STAT;
      default: sel = SEL_NONE;
    endcase
  end

  assign priv_ok = priv_i >= MinPriv;
  assign opc_ok  = (opc1_i == 3'd0) && (opc2_i == 3'd0);

  always_comb begin
    dec_o.hit   = (crn_i == 4'd15);
    dec_o.quiet = dec_o.hit && catch_all_i;
    dec_o.undef = dec_o.hit && !catch_all_i &&
                  (!priv_ok || !opc_ok || sel == SEL_NONE);
    dec_o.sel   = (dec_o.hit && !dec_o.quiet && !dec_o.undef) ? sel : SEL_NONE;
  end
endmodule

// File: rtl/impdef_regs.sv
module impdef_regs
  import impdef_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter logic [DATA_W-1:0] CFG_MASK = 'hE7,
  parameter int              CFG_ID_BIT = 5,
  parameter int              TID_W      = 16,
  parameter logic [DATA_W-1:0] PRI_ID   = 'h4100_A010,
  parameter logic [DATA_W-1:0] ALT_ID   = 'h4100_A011
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] cpu_id_o
);
  logic [DATA_W-1:0] cfg_q, upper_q, lower_q, tid_q, tid_w;

  generate
    if (TID_W >= DATA_W) begin : g_tid_full
      assign tid_w = wdata_i;
    end else begin : g_tid_part
      assign tid_w = {{(DATA_W-TID_W){1'b0}}, wdata_i[TID_W-1:0]};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      upper_q <= '0;
      lower_q <= '0;
      tid_q   <= '0;
    end else if (we_i) begin
      unique case (sel_i)
        SEL_CFG:   cfg_q   <= wdata_i & CFG_MASK;
        SEL_UPPER: upper_q <= wdata_i;
        SEL_LOWER: lower_q <= wdata_i;
        SEL_TID:   tid_q   <= tid_w;
        default:   ;
      endcase
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_CFG:   rdata_o = cfg_q;
      SEL_UPPER: rdata_o = upper_q;
      SEL_LOWER: rdata_o = lower_q;
      SEL_TID:   rdata_o = tid_q;
      default:   rdata_o = '0;
    endcase
  end

  assign cpu_id_o = cfg_q[CFG_ID_BIT] ? ALT_ID : PRI_ID;
endmodule

// File: rtl/impdef_reg_bank.sv
module impdef_reg_bank
  import impdef_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter int              PRIV_W     = 2,
  parameter int              MIN_PRIV   = 1,
  parameter logic [DATA_W-1:0] CFG_MASK = 'hE7,
  parameter int              CFG_ID_BIT = 5,
  parameter int              TID_W      = 16,
  parameter logic [DATA_W-1:0] PRI_ID   = 'h4100_A010,
  parameter logic [DATA_W-1:0] ALT_ID   = 'h4100_A011
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [3:0]        req_crn_i,
  input  logic [3:0]        req_crm_i,
  input  logic [2:0]        req_opc1_i,
  input  logic [2:0]        req_opc2_i,
  input  logic [PRIV_W-1:0] req_priv_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              catch_all_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              undef_o,
  output logic              halt_o,
  output logic [DATA_W-1:0] cpu_id_o
);
  dec_t              dec;
  logic [DATA_W-1:0] bank_rdata;
  logic              we;

  impdef_decode #(.PRIV_W(PRIV_W), .MIN_PRIV(MIN_PRIV)) i_decode (
    .crn_i       (req_crn_i),
    .crm_i       (req_crm_i),
    .opc1_i      (req_opc1_i),
    .opc2_i      (req_opc2_i),
    .priv_i      (req_priv_i),
    .catch_all_i (catch_all_i),
    .dec_o       (dec)
  );

  assign we = req_valid_i && req_write_i;

  impdef_regs #(
    .DATA_W(DATA_W), .CFG_MASK(CFG_MASK), .CFG_ID_BIT(CFG_ID_BIT),
    .TID_W(TID_W), .PRI_ID(PRI_ID), .ALT_ID(ALT_ID)
  ) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we),
    .sel_i    (dec.sel),
    .wdata_i  (req_wdata_i),
    .rdata_o  (bank_rdata),
    .cpu_id_o (cpu_id_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      undef_o <= 1'b0;
      halt_o  <= 1'b0;
    end else begin
      undef_o <= req_valid_i && dec.undef;
      halt_o  <= we && (dec.sel == SEL_STAT);
      if (req_valid_i && !req_write_i && dec.hit) rdata_o <= bank_rdata;
    end
  end
endmodule

// File: rtl/impdef_reg_bank_chk.sv
module impdef_reg_bank_chk #(
  parameter int DATA_W   = 32,
  parameter int PRIV_W   = 2,
  parameter int MIN_PRIV = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [3:0]        req_crn_i,
  input logic [3:0]        req_crm_i,
  input logic [PRIV_W-1:0] req_priv_i,
  input logic              catch_all_i,
  input logic              undef_o,
  input logic              halt_o,
  input logic [DATA_W-1:0] cpu_id_o
);
  AST_HALT_FROM_STATUS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> $past(req_valid_i && req_write_i && req_crm_i == 4'd8 && !catch_all_i)); // R6
  AST_HALT_UNDEF_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(halt_o && undef_o)); // R6
  AST_UNDEF_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> $past(req_valid_i && !catch_all_i && req_crn_i == 4'd15)); // R8
  AST_LOW_PRIV_UNDEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !catch_all_i && req_crn_i == 4'd15 &&
     req_priv_i < PRIV_W'(MIN_PRIV)) |=> undef_o); // R9
  AST_CATCH_ALL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && catch_all_i) |=> (!undef_o && !halt_o)); // R10
  AST_ID_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_write_i) |=> $stable(cpu_id_o)); // R3
endmodule

bind impdef_reg_bank impdef_reg_bank_chk #(
  .DATA_W(DATA_W), .PRIV_W(PRIV_W), .MIN_PRIV(MIN_PRIV)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_crn_i   (req_crn_i),
  .req_crm_i   (req_crm_i),
  .req_priv_i  (req_priv_i),
  .catch_all_i (catch_all_i),
  .undef_o     (undef_o),
  .halt_o      (halt_o),
  .cpu_id_o    (cpu_id_o)
);

// File: tb/test_impdef_reg_bank.sv
module test_impdef_reg_bank;
  localparam logic [31:0] PRI = 32'h4100_A010;
  localparam logic [31:0] ALT = 32'h4100_A011;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0, catch_all = 1'b0;
  logic [3:0]  crn = '0, crm = '0;
  logic [2:0]  opc1 = '0, opc2 = '0;
  logic [1:0]  priv = '0;
  logic [31:0] wdata = '0, rdata, cpu_id;
  logic        undef, halt;

  int errors = 0, checks = 0;
  logic [31:0] m_cfg = '0, m_up = '0, m_lo = '0, m_tid = '0, m_rd = '0;

  always #2.5 clk = ~clk;

  impdef_reg_bank i_impdef_reg_bank (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
    .req_crn_i(crn), .req_crm_i(crm), .req_opc1_i(opc1), .req_opc2_i(opc2),
    .req_priv_i(priv), .req_wdata_i(wdata), .catch_all_i(catch_all),
    .rdata_o(rdata), .undef_o(undef), .halt_o(halt), .cpu_id_o(cpu_id)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_id();
    return m_cfg[5] ? ALT : PRI;
  endfunction

  // one access; model updated per R2..R11, outputs checked the cycle after
  task automatic access(input logic w, input logic [3:0] n, input logic [3:0] m,
                        input logic [2:0] o1, input logic [2:0] o2, input logic [1:0] p,
                        input logic [31:0] d, input logic ca, input string req);
    logic hit, legal, e_undef, e_halt;
    logic [31:0] val;
    @(negedge clk);
    valid = 1'b1; write = w; crn = n; crm = m; opc1 = o1; opc2 = o2;
    priv = p; wdata = d; catch_all = ca;
    hit   = (n == 4'd15);
    legal = (p >= 2'd1) && (o1 == 0) && (o2 == 0) &&
            (m inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd8});
    e_undef = hit && !ca && !legal;
    e_halt  = hit && !ca && legal && w && (m == 4'd8);
    val = '0;
    if (hit && !ca && legal) begin
      case (m)
        4'd1: val = m_cfg;
        4'd2: val = m_up;
        4'd3: val = m_lo;
        4'd4: val = m_tid;
        default: val = '0;
      endcase
      if (w) begin
        case (m)
          4'd1: m_cfg = d & 32'hE7;
          4'd2: m_up  = d;
          4'd3: m_lo  = d;
          4'd4: m_tid = {16'h0, d[15:0]};
          default: ;
        endcase
      end
    end
    if (hit && !w) m_rd = val;
    @(negedge clk);
    valid = 1'b0;
    chk({req, " rdata"}, rdata, m_rd);
    chk({req, " undef"}, {31'h0, undef}, {31'h0, e_undef});
    chk({req, " halt"},  {31'h0, halt},  {31'h0, e_halt});
    chk({req, " cpu_id"}, cpu_id, exp_id());
  endtask

  task automatic idle_chk(string req);
    @(negedge clk);
    chk({req, " halt idle"},  {31'h0, halt},  32'h0);
    chk({req, " undef idle"}, {31'h0, undef}, 32'h0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, '0);
    chk("R1 undef", {31'h0, undef}, '0);
    chk("R1 halt", {31'h0, halt}, '0);
    chk("R1 cpu_id", cpu_id, PRI);
    for (int m = 1; m <= 4; m++) access(1'b0, 4'd15, m[3:0], 0, 0, 2'd1, '0, 1'b0, "R1 readback");

    // R2/R3 config mask and ID select
    access(1'b1, 4'd15, 4'd1, 0, 0, 2'd1, 32'hFFFF_FFFF, 1'b0, "R2 cfg write");
    access(1'b0, 4'd15, 4'd1, 0, 0, 2'd1, '0, 1'b0, "R2 cfg mask");
    access(1'b1, 4'd15, 4'd1, 0, 0, 2'd3, 32'h0000_00DF, 1'b0, "R3 bit5 clear");
    access(1'b1, 4'd15, 4'd1, 0, 0, 2'd2, 32'h0000_0020, 1'b0, "R3 bit5 set");
    // R4/R5
    access(1'b1, 4'd15, 4'd2, 0, 0, 2'd1, 32'hA5C3_0F96, 1'b0, "R4 upper");
    access(1'b1, 4'd15, 4'd3, 0, 0, 2'd1, 32'h8000_0001, 1'b0, "R4 lower");
    access(1'b1, 4'd15, 4'd4, 0, 0, 2'd1, 32'hDEAD_BEEF, 1'b0, "R5 tid");
    for (int m = 1; m <= 4; m++) access(1'b0, 4'd15, m[3:0], 0, 0, 2'd1, '0, 1'b0, "R4 R5 readback");
    // R6 halt pulse, then gone
    access(1'b1, 4'd15, 4'd8, 0, 0, 2'd1, 32'h1, 1'b0, "R6 status write");
    idle_chk("R6");
    access(1'b0, 4'd15, 4'd8, 0, 0, 2'd1, '0, 1'b0, "R6 status read");

    // R7..R10 sweep: every crm, opcode variants, privileges, both modes
    for (int ca = 0; ca < 2; ca++)
      for (int m = 0; m < 16; m++)
        for (int o = 0; o < 3; o++)
          for (int p = 0; p < 4; p++)
            for (int w = 0; w < 2; w++) begin
              logic [31:0] d;
              d = 32'h9E37_79B9 * (m * 24 + o * 8 + p * 2 + w + ca * 400 + 1);
              access(w[0], 4'd15, m[3:0], (o == 1) ? 3'd2 : 3'd0, (o == 2) ? 3'd1 : 3'd0,
                     p[1:0], d, ca[0], "R7 R8 R9 R10 sweep");
            end
    // R10 catch-all must not change stored state
    for (int m = 1; m <= 4; m++) access(1'b0, 4'd15, m[3:0], 0, 0, 2'd1, '0, 1'b0, "R10 readback");

    // R11 other crn untouched, rdata holds
    access(1'b1, 4'd7, 4'd1, 0, 0, 2'd3, 32'hFFFF_FFFF, 1'b0, "R11 other crn write");
    access(1'b0, 4'd0, 4'd2, 0, 0, 2'd3, '0, 1'b0, "R11 other crn read");
    idle_chk("R11");
    chk("R11 rdata hold", rdata, m_rd);
    for (int m = 1; m <= 4; m++) access(1'b0, 4'd15, m[3:0], 0, 0, 2'd1, '0, 1'b0, "R11 readback");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule